// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous request port and an external clockless static RAM that is 32 bits wide with 17 address bits. A client presents a request carrying a direction, a word address, write data and a four-bit byte mask. The controller then runs the RAM strobes through a fixed sequence of phases. Those strobes are one active-low chip enable per byte lane, an active-low write strobe and an active-low output enable. It also decides when the shared data bus is driven. Every timing interval is a whole number of clock cycles, rounded up from the RAM's nanosecond figure and the clock period.

A read asserts the selected byte enables and the output enable. The controller waits the access time, samples the bus and returns the word with a one-cycle done pulse. After that it releases the bus for a turnaround interval, so a following write cannot fight the RAM's decaying drivers. A write drives the data and the selected byte enables for a setup phase with the write strobe high. It then pulls the write strobe low for the pulse width and releases everything together, which is allowed because the RAM needs zero hold and zero recovery time. The data path is split into an output value, an input value and a drive-enable flag, so the pad-level tri-state buffer lives outside this block.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, all four byte enables, the write strobe and the output enable are high, the bus is not driven, and both busy and done are low.
- R2: A request is accepted only when busy is low. A request presented while busy is high has no effect on the RAM contents or on the responses.
- R3: From the cycle after a read is accepted, the address is on the RAM address pins and a byte enable is low exactly where the mask bit is 1 (bit i selects data bits 8i+7..8i). The output enable is low, the write strobe is high and the bus is not driven.
- R4: The read data is sampled after the output enable has been low for ACCESS_CYC+1 cycles. The done pulse and the data appear in cycle ACCESS_CYC+2 after the accept edge. Byte lanes not selected by the mask read back as zero.
- R5: The controller never drives the bus while the output enable is low. After a read it keeps the bus undriven and stays busy for TURN_CYC cycles after the output enable rises, so busy falls in cycle ACCESS_CYC+TURN_CYC+2.
- R6: During a write the output enable stays high. The selected byte enables are low and the bus is driven from the first cycle after accept until the write strobe rises.
- R7: During a write the data is driven with the write strobe high for exactly SETUP_CYC cycles, and then the write strobe is low for exactly PULSE_CYC cycles.
- R8: The driven write data is stable while the write strobe is low. Only the bytes selected by the mask change in the RAM.
- R9: The write done pulse occurs in cycle SETUP_CYC+PULSE_CYC+1 after the accept edge, with busy already low, so a new request may be accepted in that cycle.
- R10: Done is high for exactly one cycle per completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 32 | Write data |
| reqMask | input | 4 | Byte lane select, bit i for bits 8i+7..8i |
| busy | output | 1 | Cycle in progress, requests ignored |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 32 | Read data, valid with rspDone after a read |
| ramAddr | output | 17 | RAM address |
| ramCeN | output | 4 | Active-low byte chip enables |
| ramWeN | output | 1 | Active-low write strobe |
| ramOeN | output | 1 | Active-low output enable |
| ramDout | output | 32 | Data toward the RAM |
| ramDriveEn | output | 1 | Drive ramDout onto the shared bus |
| ramDin | input | 32 | Data from the shared bus |

## Verification
A sequencer stuck in the wrong state shows up at the RAM pins in the very next cycle, because every strobe is a register loaded from the next state. A wrong phase counter changes the write-strobe low run or the setup run by whole cycles. It also moves the done pulse away from cycle ACCESS_CYC+2 or SETUP_CYC+PULSE_CYC+1, and those are counted exactly. A capture taken too early returns the bus model's placeholder pattern instead of stored data. A lost mask or a lost turnaround shows up either as damaged neighbouring bytes on readback or as the bus being driven too soon after the output enable rises.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_TURNAROUND
  } ctrlState_t;

  // Strobes from control to datapath. The pin-level fields describe the
  // next cycle; load, capture and finish describe the current cycle.
  typedef struct packed {
    logic load;
    logic ceAct;
    logic weAct;
    logic oeAct;
    logic drive;
    logic capture;
    logic finish;
  } ctrlStrobes_t;

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ACCESS_CYC = 4,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int TURN_CYC   = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         busy,
  output ctrlStrobes_t strobes
);

  localparam int MAX_A = (ACCESS_CYC > SETUP_CYC) ? ACCESS_CYC : SETUP_CYC;
  localparam int MAX_B = (PULSE_CYC > TURN_CYC) ? PULSE_CYC : TURN_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  ctrlState_t state, nextState;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] phaseLen;
  logic lastCyc;

  always_comb begin
    case (state)
      ST_RD_ACCESS:  phaseLen = CNT_W'(ACCESS_CYC);
      ST_WR_SETUP:   phaseLen = CNT_W'(SETUP_CYC);
      ST_WR_PULSE:   phaseLen = CNT_W'(PULSE_CYC);
      ST_TURNAROUND: phaseLen = CNT_W'(TURN_CYC);
      default:       phaseLen = CNT_W'(1);
    endcase
  end

  assign lastCyc = (phaseCnt == phaseLen - CNT_W'(1));

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:       if (reqValid) nextState = reqWrite ? ST_WR_SETUP : ST_RD_ACCESS;
      ST_RD_ACCESS:  if (lastCyc) nextState = ST_RD_CAPTURE;
      ST_RD_CAPTURE: nextState = ST_TURNAROUND;
      ST_WR_SETUP:   if (lastCyc) nextState = ST_WR_PULSE;
      ST_WR_PULSE:   if (lastCyc) nextState = ST_IDLE;
      ST_TURNAROUND: if (lastCyc) nextState = ST_IDLE;
      default:       nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state <= nextState;
      if (nextState != state || state == ST_IDLE) phaseCnt <= '0;
      else phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobes.load    = (state == ST_IDLE) && reqValid;
    strobes.ceAct   = (nextState != ST_IDLE) && (nextState != ST_TURNAROUND);
    strobes.weAct   = (nextState == ST_WR_PULSE);
    strobes.oeAct   = (nextState == ST_RD_ACCESS) || (nextState == ST_RD_CAPTURE);
    strobes.drive   = (nextState == ST_WR_SETUP) || (nextState == ST_WR_PULSE);
    strobes.capture = (state == ST_RD_CAPTURE);
    strobes.finish  = (state == ST_WR_PULSE) && lastCyc;
  end

  assign busy = (state != ST_IDLE);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy); // R2

  AST_CAPTURE_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> $past(state) == ST_RD_ACCESS); // R4

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 32,
  parameter int LANES     = 4,
  parameter int PULSE_CYC = 3,
  parameter int TURN_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] ramDin,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [LANES-1:0]  ramCeN,
  output logic              ramWeN,
  output logic              ramOeN,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDriveEn,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone
);

  localparam int LANE_W = DATA_W / LANES;
  localparam int TURN_W = $clog2(TURN_CYC + 1);
  localparam int PW_W   = $clog2(PULSE_CYC + 2);

  logic [LANES-1:0]  maskReg;
  logic [LANES-1:0]  maskNext;
  logic [DATA_W-1:0] laneMasked;

  assign maskNext = strobes.load ? reqMask : maskReg;

  for (genvar i = 0; i < LANES; i++) begin : gLane
    assign laneMasked[i*LANE_W +: LANE_W] =
      maskReg[i] ? ramDin[i*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg    <= '0;
      ramAddr    <= '0;
      ramDout    <= '0;
      ramCeN     <= '1;
      ramWeN     <= 1'b1;
      ramOeN     <= 1'b1;
      ramDriveEn <= 1'b0;
      rspData    <= '0;
      rspDone    <= 1'b0;
    end else begin
      if (strobes.load) begin
        maskReg <= reqMask;
        ramAddr <= reqAddr;
        ramDout <= reqWdata;
      end
      ramCeN     <= strobes.ceAct ? ~maskNext : '1;
      ramWeN     <= ~strobes.weAct;
      ramOeN     <= ~strobes.oeAct;
      ramDriveEn <= strobes.drive;
      if (strobes.capture) rspData <= laneMasked;
      rspDone    <= strobes.capture | strobes.finish;
    end
  end

  // Pin-timing observers used only by the assertions below
  logic [TURN_W-1:0] oeHighCnt;
  logic [PW_W-1:0]   weLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeHighCnt <= TURN_W'(TURN_CYC);
      weLowCnt  <= '0;
    end else begin
      if (!ramOeN) oeHighCnt <= '0;
      else if (oeHighCnt != TURN_W'(TURN_CYC)) oeHighCnt <= oeHighCnt + TURN_W'(1);
      if (ramWeN) weLowCnt <= '0;
      else if (weLowCnt != PW_W'(PULSE_CYC + 1)) weLowCnt <= weLowCnt + PW_W'(1);
    end
  end

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    !(ramDriveEn && !ramOeN)); // R5

  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramDriveEn) |-> oeHighCnt == TURN_W'(TURN_CYC)); // R5

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> weLowCnt == PW_W'(PULSE_CYC)); // R7

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> (ramOeN && ramDriveEn)); // R6

  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ramWeN && !$past(ramWeN)) |-> $stable(ramDout)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R10

  AST_CE_IN_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (~ramCeN & ~maskReg) == '0); // R3

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 32,
  parameter int ACCESS_CYC = 4,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int TURN_CYC   = 2,
  localparam int LANES     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              busy,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [LANES-1:0]  ramCeN,
  output logic              ramWeN,
  output logic              ramOeN,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDriveEn,
  input  logic [DATA_W-1:0] ramDin
);

  ctrlStrobes_t strobes;

  sram_ctrl_fsm #(
    .ACCESS_CYC(ACCESS_CYC), .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),   .TURN_CYC(TURN_CYC)
  ) uFsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .busy(busy), .strobes(strobes)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
    .PULSE_CYC(PULSE_CYC), .TURN_CYC(TURN_CYC)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .ramDin(ramDin), .ramAddr(ramAddr), .ramCeN(ramCeN),
    .ramWeN(ramWeN), .ramOeN(ramOeN), .ramDout(ramDout),
    .ramDriveEn(ramDriveEn), .rspData(rspData), .rspDone(rspDone)
  );

endmodule

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;
  localparam int A = 4, S = 2, P = 3, T = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, reqValid, reqWrite, busy, rspDone, ramWeN, ramOeN, ramDriveEn;
  logic [16:0] reqAddr, ramAddr;
  logic [31:0] reqWdata, rspData, ramDout, ramDin;
  logic [3:0]  reqMask, ramCeN;

  int nChecks = 0, nFails = 0;

  sram_cycle_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .busy(busy), .rspDone(rspDone), .rspData(rspData),
    .ramAddr(ramAddr), .ramCeN(ramCeN), .ramWeN(ramWeN), .ramOeN(ramOeN),
    .ramDout(ramDout), .ramDriveEn(ramDriveEn), .ramDin(ramDin)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // RAM model: a lane returns stored data only once the output enable has been
  // low for A cycles; otherwise it shows a placeholder pattern
  logic [31:0] mem [0:255];
  int oeCnt = 0;
  always_comb begin
    for (int i = 0; i < 4; i++)
      ramDin[i*8 +: 8] = (!ramCeN[i] && ramWeN && !ramOeN && oeCnt >= A)
                         ? mem[ramAddr[7:0]][i*8 +: 8] : 8'h5A;
  end
  always @(posedge clk) begin
    oeCnt <= ramOeN ? 0 : oeCnt + 1;
    if (rstN && !ramWeN)
      for (int i = 0; i < 4; i++)
        if (!ramCeN[i]) mem[ramAddr[7:0]][i*8 +: 8] <= ramDout[i*8 +: 8];
  end

  // Pin monitor
  logic prevWeN = 1'b1, prevDrive = 1'b0;
  logic [31:0] prevDout = '0;
  int weRun = 0, setupRun = 0, oeHighRun = 100;
  always @(negedge clk) begin
    if (rstN) begin
      if (!ramOeN) oeHighRun = 0; else oeHighRun++;
      if (ramDriveEn && !prevDrive) chk(oeHighRun > T, "R5 gap before drive", oeHighRun, T + 1);
      if (!ramWeN) begin
        weRun++;
        chk(ramOeN && ramDriveEn, "R6 oe/drive in pulse", {ramOeN, ramDriveEn}, 2'b11);
        if (!prevWeN) chk(ramDout == prevDout, "R8 data stable", ramDout, prevDout);
        if (prevWeN) begin
          chk(setupRun == S, "R7 setup length", setupRun, S);
          setupRun = 0;
        end
      end else begin
        if (!prevWeN) begin
          chk(weRun == P, "R7 pulse length", weRun, P);
          weRun = 0;
        end
        if (ramDriveEn) setupRun++; else setupRun = 0;
      end
      prevWeN = ramWeN; prevDout = ramDout; prevDrive = ramDriveEn;
    end
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWdata = 32'hFFFF_FFFF; reqAddr = '0;
  endtask

  task automatic doWrite(input logic [16:0] a, input logic [31:0] d, input logic [3:0] m);
    int n = 1;
    issue(1'b1, a, d, m);
    chk(ramCeN == ~m && ramOeN && ramDriveEn && ramWeN, "R6 first write cycle",
        {ramCeN, ramOeN, ramDriveEn, ramWeN}, {~m, 3'b111});
    chk(ramAddr == a && ramDout == d, "R6 write addr/data", ramDout, d);
    while (!rspDone && n < 50) begin @(negedge clk); n++; end
    chk(n == S + P + 1, "R9 write done cycle", n, S + P + 1);
    chk(!busy, "R9 busy low at done", busy, 0);
    @(negedge clk);
    chk(!rspDone, "R10 single done", rspDone, 0);
  endtask

  task automatic doRead(input logic [16:0] a, input logic [3:0] m, input logic [31:0] exp,
                        input bit intrude);
    int n = 1;
    int dones = 0;
    issue(1'b0, a, 32'h0, m);
    chk(ramCeN == ~m && ramWeN && !ramOeN && !ramDriveEn && ramAddr == a,
        "R3 read strobes", {ramCeN, ramWeN, ramOeN, ramDriveEn}, {~m, 3'b100});
    while (n < 50 && (busy || rspDone)) begin
      if (intrude && n == 2) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = 32'h0BAD_0BAD; reqMask = 4'hF;
      end else reqValid = 1'b0;
      if (rspDone) begin
        dones++;
        chk(n == A + 2, "R4 read done cycle", n, A + 2);
        chk(rspData == exp, "R4 read data", rspData, exp);
      end
      @(negedge clk); n++;
    end
    reqValid = 1'b0;
    chk(n == A + T + 2, "R5 busy falls after turnaround", n, A + T + 2);
    chk(dones == 1, "R10 one done per read", dones, 1);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0; reqMask = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(ramCeN == 4'hF && ramWeN && ramOeN && !ramDriveEn && !busy && !rspDone,
        "R1 reset state", {ramCeN, ramWeN, ramOeN, ramDriveEn, busy, rspDone}, 9'h1F8);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(ramCeN == 4'hF && ramWeN && ramOeN && !busy, "R1 idle after reset", ramCeN, 4'hF);

    doWrite(17'h00010, 32'hDEAD_BEEF, 4'hF);
    doRead(17'h00010, 4'hF, 32'hDEAD_BEEF, 1'b0);
    doWrite(17'h00010, 32'h1122_3344, 4'b0101);          // R8 masked write
    doRead(17'h00010, 4'hF, 32'hDE22_BE44, 1'b0);
    doRead(17'h00010, 4'b0010, 32'h0000_BE00, 1'b0);     // R4 unselected lanes zero
    doWrite(17'h1FFFF, 32'hCAFE_F00D, 4'hF);
    doWrite(17'h00020, 32'h0102_0304, 4'b1000);          // back to back writes
    doRead(17'h1FFFF, 4'hF, 32'hCAFE_F00D, 1'b1);        // R2 intruding write ignored
    doRead(17'h1FFFF, 4'hF, 32'hCAFE_F00D, 1'b0);        // R2 contents unchanged
    doRead(17'h00020, 4'b1100, 32'h0100_0000, 1'b0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule